// File: doc/BRIEF.md
# I2C Byte Queue and Interrupt Hub

This block sits between a register bus and an I2C bus engine. Software writes outgoing bytes into a 16-entry transmit queue through a data register. The engine drains that queue over a valid/ready byte stream. Bytes the engine receives arrive on a second valid/ready stream and wait in a 16-entry receive queue until software pops them through a read register. Each queue has a 4-bit programmable threshold that shapes its "nearly empty" or "nearly full" flag. Each queue also has a flush command that runs for a fixed number of cycles and reports its own completion.

All queue conditions and all engine events are collected in a 32-bit raw status word at fixed bit positions. The engine's events are transfer done, done without stop, arbitration lost and bus error. Queue conditions are live levels. Events and the transmit overrun are sticky until software writes one to them in the clear register. A mask register selects which raw bits reach the masked status word, and the single interrupt line is the OR of that masked word.

Top module: `bqi_top`

Register word addresses (`reg_addr`): 0 control, 1 TX threshold, 2 RX threshold, 3 mask, 4 raw status, 5 masked status, 6 clear (write only), 7 TX data (write only), 8 RX data (read pops). Reads are combinational.

## Requirements
- R1: After reset both queues are empty, the TX threshold is 0, the RX threshold is 1, the mask is 0, raw status reads 0x00000013, masked status reads 0, `irq` is low and `tx_vld` is low.
- R2: Bytes written to address 7 leave on `tx_data` in write order, one per cycle in which `tx_vld` and `tx_rdy` are both high. The queue holds 16 bytes.
- R3: A write to address 7 while the TX queue holds 16 bytes sets raw bit 3 (TX overrun). That byte is discarded and never appears on `tx_data`.
- R4: Bytes accepted on `rx_data` (when `rx_vld` and `rx_rdy` are high) are returned in order by reads of address 8, each read removing one byte. A read of address 8 with the RX queue empty returns 0 and removes nothing.
- R5: Raw bit 0 is high when the TX queue is empty and bit 2 when it holds 16 bytes. Bit 4 is high when the RX queue is empty and bit 6 when it holds 16 bytes. `rx_rdy` is low while the RX queue is full.
- R6: Raw bit 1 is high when the TX count is at most the TX threshold (address 1, bits 3:0). Raw bit 5 is high when the RX count is at least the RX threshold (address 2, bits 3:0).
- R7: Writing 1 to control bit 7 (TX) or bit 8 (RX) starts a flush lasting FLUSH_CYC cycles. During the flush the bit reads back as 1 and the queue neither accepts nor delivers bytes. When the flush ends the bit reads 0 and the queue is empty.
- R8: Pulses on `ev_done`, `ev_arb_lost`, `ev_bus_err` and `ev_done_nostop` set raw bits 19, 24, 25 and 28. These bits stay set until cleared. A pulse in the same cycle as a clear of that bit leaves the bit set.
- R9: Writing 1 to a bit of address 6 clears that sticky raw bit, and writing 0 leaves it unchanged. The level bits 0, 1, 2, 4, 5 and 6 cannot be cleared.
- R10: Masked status equals raw status AND the mask, and `irq` is high exactly when masked status is nonzero. Mask bits 31:29 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops RX on address 8) |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational |
| tx_vld | output | 1 | TX byte available to the engine |
| tx_rdy | input | 1 | Engine takes the TX byte |
| tx_data | output | 8 | TX byte at queue head |
| rx_vld | input | 1 | Engine offers an RX byte |
| rx_rdy | output | 1 | RX queue accepts a byte |
| rx_data | input | 8 | RX byte from the engine |
| ev_done | input | 1 | Transfer finished with stop |
| ev_done_nostop | input | 1 | Transfer finished without stop |
| ev_arb_lost | input | 1 | Arbitration lost |
| ev_bus_err | input | 1 | Bus error |
| irq | output | 1 | Combined interrupt |

## Verification
The bench fills the TX queue to exactly 16 bytes and then writes a 17th. A design that let the extra byte overwrite the queue, or that failed to raise overrun, shows up as a wrong or extra byte on the drained stream, or as a missing bit 3. Both thresholds are probed on each side of the boundary. An off-by-one comparison there flips bit 1 or bit 5 at the wrong count. The bench also reads an empty RX queue and then checks that the next real byte still comes out, which catches a pointer that moves on an empty pop. It issues a clear in the same cycle as a bus-error pulse, clears with zeros, and tries to clear a level bit, so a clear that wins over set, a write that clears everything, or a clearable level bit each leave a wrong raw value.

// File: rtl/bqi_pkg.sv
package bqi_pkg;
  localparam int THR_W = 4;

  localparam logic [3:0] A_CTRL   = 4'd0;
  localparam logic [3:0] A_TXTHR  = 4'd1;
  localparam logic [3:0] A_RXTHR  = 4'd2;
  localparam logic [3:0] A_MASK   = 4'd3;
  localparam logic [3:0] A_RAW    = 4'd4;
  localparam logic [3:0] A_MSTAT  = 4'd5;
  localparam logic [3:0] A_CLR    = 4'd6;
  localparam logic [3:0] A_TXDATA = 4'd7;
  localparam logic [3:0] A_RXDATA = 4'd8;

  localparam int B_TXE  = 0;
  localparam int B_TXNE = 1;
  localparam int B_TXF  = 2;
  localparam int B_TXOV = 3;
  localparam int B_RXE  = 4;
  localparam int B_RXNF = 5;
  localparam int B_RXF  = 6;
  localparam int B_DONE = 19;
  localparam int B_ARB  = 24;
  localparam int B_BERR = 25;
  localparam int B_DNS  = 28;

  localparam logic [31:0] CLEARABLE = 32'h131F_007F;
  localparam logic [31:0] STICKY    = 32'h1308_0008;
  localparam logic [31:0] LEVELS    = 32'h0000_0077;
  localparam logic [31:0] LIVE      = 32'h1FFF_FFFF;

  // TX flags are low-side, RX flags are high-side
  function automatic logic tx_low(input int cnt, input int thr);
    return cnt <= thr;
  endfunction

  function automatic logic rx_high(input int cnt, input int thr);
    return cnt >= thr;
  endfunction

  function automatic logic [31:0] level_word(input int txc, input int rxc,
                                             input int txthr, input int rxthr,
                                             input int depth);
    logic [31:0] w;
    w = '0;
    w[B_TXE]  = (txc == 0);
    w[B_TXNE] = tx_low(txc, txthr);
    w[B_TXF]  = (txc == depth);
    w[B_RXE]  = (rxc == 0);
    w[B_RXNF] = rx_high(rxc, rxthr);
    w[B_RXF]  = (rxc == depth);
    return w;
  endfunction
endpackage

// File: rtl/bqi_fifo.sv
module bqi_fifo #(
  parameter int DEPTH     = 16,
  parameter int DW        = 8,
  parameter int FLUSH_CYC = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [DW-1:0]                push_data,
  input  logic                         pop,
  input  logic                         flush_req,
  output logic [DW-1:0]                head,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         flushing
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int FW = $clog2(FLUSH_CYC + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [FW-1:0] fcnt;
  logic          full, empty, push_ok, pop_ok, flush_end;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full      = (count == CW'(DEPTH));
  assign empty     = (count == '0);
  assign flushing  = (fcnt != '0);
  assign flush_end = (fcnt == FW'(1));
  assign push_ok   = push && !full && !flushing;
  assign pop_ok    = pop && !empty && !flushing;
  assign head      = empty ? '0 : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n)             fcnt <= '0;
    else if (flushing)      fcnt <= fcnt - FW'(1);
    else if (flush_req)     fcnt <= FW'(FLUSH_CYC);
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush_end) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= step(wr_ptr);
      if (pop_ok)  rd_ptr <= step(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R7
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flushing) |-> count == '0);
  // R4
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop && !push && empty |=> count == '0);
endmodule

// File: rtl/bqi_irq.sv
module bqi_irq
  import bqi_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] level_in,
  input  logic [31:0] event_in,
  input  logic        mask_we,
  input  logic        clr_we,
  input  logic [31:0] wdata,
  output logic [31:0] raw,
  output logic [31:0] mask,
  output logic [31:0] masked
);
  logic [31:0] sticky, clr_bits;

  assign clr_bits = clr_we ? (wdata & CLEARABLE) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) sticky <= '0;
    else        sticky <= ((sticky & ~clr_bits) | event_in) & STICKY;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       mask <= '0;
    else if (mask_we) mask <= wdata & LIVE;
  end

  assign raw    = (sticky & STICKY) | (level_in & LEVELS);
  assign masked = raw & mask;

  // R8
  arb_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    event_in[B_ARB] |=> raw[B_ARB]);
  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    raw[B_DONE] && !(clr_we && wdata[B_DONE]) |=> raw[B_DONE]);
  // R9
  berr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we && wdata[B_BERR] && !event_in[B_BERR] |=> !raw[B_BERR]);
endmodule

// File: rtl/bqi_top.sv
module bqi_top
  import bqi_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int FLUSH_CYC = 4,
  parameter int TXTHR_RST = 0,
  parameter int RXTHR_RST = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        tx_vld,
  input  logic        tx_rdy,
  output logic [7:0]  tx_data,
  input  logic        rx_vld,
  output logic        rx_rdy,
  input  logic [7:0]  rx_data,
  input  logic        ev_done,
  input  logic        ev_done_nostop,
  input  logic        ev_arb_lost,
  input  logic        ev_bus_err,
  output logic        irq
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0]    tx_cnt, rx_cnt;
  logic             tx_fl, rx_fl;
  logic [7:0]       rx_head;
  logic [THR_W-1:0] tx_thr, rx_thr;
  logic [31:0]      lvl, evt, raw, mask, masked;
  logic             wr_ctrl, wr_txd, rd_rxd, tx_full, txd_overrun;

  assign wr_ctrl     = reg_wr && (reg_addr == A_CTRL);
  assign wr_txd      = reg_wr && (reg_addr == A_TXDATA);
  assign rd_rxd      = reg_rd && (reg_addr == A_RXDATA);
  assign tx_full     = (tx_cnt == CW'(DEPTH));
  assign txd_overrun = wr_txd && tx_full;

  bqi_fifo #(.DEPTH(DEPTH), .DW(8), .FLUSH_CYC(FLUSH_CYC)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .push(wr_txd), .push_data(reg_wdata[7:0]),
    .pop(tx_rdy), .flush_req(wr_ctrl && reg_wdata[7]),
    .head(tx_data), .count(tx_cnt), .flushing(tx_fl));

  bqi_fifo #(.DEPTH(DEPTH), .DW(8), .FLUSH_CYC(FLUSH_CYC)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .push(rx_vld), .push_data(rx_data),
    .pop(rd_rxd), .flush_req(wr_ctrl && reg_wdata[8]),
    .head(rx_head), .count(rx_cnt), .flushing(rx_fl));

  assign tx_vld = (tx_cnt != '0) && !tx_fl;
  assign rx_rdy = (rx_cnt != CW'(DEPTH)) && !rx_fl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_thr <= THR_W'(TXTHR_RST);
      rx_thr <= THR_W'(RXTHR_RST);
    end else if (reg_wr) begin
      if (reg_addr == A_TXTHR) tx_thr <= reg_wdata[THR_W-1:0];
      if (reg_addr == A_RXTHR) rx_thr <= reg_wdata[THR_W-1:0];
    end
  end

  assign lvl = level_word(int'(tx_cnt), int'(rx_cnt), int'(tx_thr),
                          int'(rx_thr), DEPTH);

  always_comb begin
    evt         = '0;
    evt[B_TXOV] = txd_overrun;
    evt[B_DONE] = ev_done;
    evt[B_ARB]  = ev_arb_lost;
    evt[B_BERR] = ev_bus_err;
    evt[B_DNS]  = ev_done_nostop;
  end

  bqi_irq u_irq (
    .clk(clk), .rst_n(rst_n), .level_in(lvl), .event_in(evt),
    .mask_we(reg_wr && (reg_addr == A_MASK)),
    .clr_we(reg_wr && (reg_addr == A_CLR)),
    .wdata(reg_wdata), .raw(raw), .mask(mask), .masked(masked));

  assign irq = |masked;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:   begin reg_rdata[7] = tx_fl; reg_rdata[8] = rx_fl; end
      A_TXTHR:  reg_rdata[THR_W-1:0] = tx_thr;
      A_RXTHR:  reg_rdata[THR_W-1:0] = rx_thr;
      A_MASK:   reg_rdata = mask;
      A_RAW:    reg_rdata = raw;
      A_MSTAT:  reg_rdata = masked;
      A_RXDATA: reg_rdata[7:0] = rx_head;
      default:  reg_rdata = '0;
    endcase
  end

  // R3
  overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_txd && tx_full |=> raw[B_TXOV]);
  // R10
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (raw & mask) != '0);
endmodule

// File: tb/bqi_top_tb.sv
module bqi_top_tb;
  localparam int FLC = 4;

  logic        clk = 0, rst_n = 0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [3:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        tx_vld, tx_rdy = 0, rx_vld = 0, rx_rdy;
  logic [7:0]  tx_data, rx_data = 0;
  logic        ev_done = 0, ev_done_nostop = 0, ev_arb_lost = 0, ev_bus_err = 0;
  logic        irq;

  int n_chk = 0, n_err = 0;
  logic [7:0] txq[$];
  logic [7:0] rxq[$];

  always #10 clk = ~clk;

  bqi_top #(.FLUSH_CYC(FLC)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_vld(tx_vld), .tx_rdy(tx_rdy), .tx_data(tx_data),
    .rx_vld(rx_vld), .rx_rdy(rx_rdy), .rx_data(rx_data),
    .ev_done(ev_done), .ev_done_nostop(ev_done_nostop),
    .ev_arb_lost(ev_arb_lost), .ev_bus_err(ev_bus_err), .irq(irq));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_rd = 1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic tx_put(input logic [7:0] b, input bit expect_keep);
    if (expect_keep) txq.push_back(b);
    wr(4'd7, {24'd0, b});
  endtask

  task automatic rx_send(input logic [7:0] b);
    rx_vld = 1; rx_data = b;
    #1 if (rx_rdy) rxq.push_back(b);
    @(negedge clk);
    rx_vld = 0;
  endtask

  task automatic pulse(input int which);
    case (which)
      0: ev_done = 1;
      1: ev_arb_lost = 1;
      2: ev_bus_err = 1;
      default: ev_done_nostop = 1;
    endcase
    @(negedge clk);
    ev_done = 0; ev_arb_lost = 0; ev_bus_err = 0; ev_done_nostop = 0;
  endtask

  // Scoreboard monitor for the TX stream
  always @(negedge clk) begin
    #2;
    if (rst_n && tx_vld && tx_rdy) begin
      if (txq.size() == 0) chk(0, "R3 unexpected TX byte", {24'd0, tx_data}, 32'd0);
      else begin
        logic [7:0] e;
        e = txq.pop_front();
        chk(tx_data == e, "R2 TX order", {24'd0, tx_data}, {24'd0, e});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd(4'd4, d); chk(d == 32'h13, "R1 raw", d, 32'h13);
    rd(4'd5, d); chk(d == 0, "R1 masked", d, 0);
    chk(irq == 0, "R1 irq", {31'd0, irq}, 0);
    chk(tx_vld == 0, "R1 tx_vld", {31'd0, tx_vld}, 0);
    rd(4'd0, d); chk(d == 0, "R1 ctrl", d, 0);

    // R6 TX threshold boundary
    wr(4'd1, 32'd3);
    for (int i = 0; i < 3; i++) tx_put(8'h10 + 8'(i), 1);
    rd(4'd4, d); chk(d[1] == 1, "R6 tx nearly empty at thr", d, 32'h2);
    tx_put(8'h13, 1);
    rd(4'd4, d); chk(d[1] == 0, "R6 tx nearly empty above thr", d, 0);
    for (int i = 4; i < 16; i++) tx_put(8'h10 + 8'(i), 1);
    rd(4'd4, d);
    chk(d[2] == 1 && d[0] == 0, "R5 tx full", d, 32'h4);
    chk(d[3] == 0, "R3 no overrun yet", d, 0);
    tx_put(8'hEE, 0);
    rd(4'd4, d); chk(d[3] == 1, "R3 overrun set", d, 32'h8);

    // R2 drain, scoreboard compares; extra byte must not appear
    tx_rdy = 1;
    repeat (24) @(negedge clk);
    tx_rdy = 0;
    chk(tx_vld == 0, "R3 dropped byte absent", {31'd0, tx_vld}, 0);
    chk(txq.size() == 0, "R2 all bytes delivered", txq.size(), 0);
    rd(4'd4, d); chk(d[0] == 1, "R5 tx empty", d, 1);
    wr(4'd6, 32'h8);
    rd(4'd4, d); chk(d[3] == 0, "R9 overrun cleared", d, 0);

    // R6 RX threshold boundary, R5 full
    wr(4'd2, 32'd5);
    for (int i = 0; i < 4; i++) rx_send(8'hA0 + 8'(i));
    rd(4'd4, d); chk(d[5] == 0, "R6 rx nearly full below thr", d, 0);
    rx_send(8'hA4);
    rd(4'd4, d); chk(d[5] == 1, "R6 rx nearly full at thr", d, 32'h20);
    for (int i = 5; i < 16; i++) rx_send(8'hA0 + 8'(i));
    rd(4'd4, d); chk(d[6] == 1 && d[4] == 0, "R5 rx full", d, 32'h40);
    #1 chk(rx_rdy == 0, "R5 rx_rdy low when full", {31'd0, rx_rdy}, 0);
    rx_send(8'h77);
    chk(rxq.size() == 16, "R5 full rejects byte", rxq.size(), 16);
    while (rxq.size() > 0) begin
      logic [7:0] e;
      e = rxq.pop_front();
      rd(4'd8, d); chk(d == {24'd0, e}, "R4 rx order", d, {24'd0, e});
    end
    rd(4'd8, d); chk(d == 0, "R4 empty read zero", d, 0);
    rd(4'd4, d); chk(d[4] == 1, "R5 rx empty", d, 32'h10);
    rx_send(8'h5A);
    rd(4'd8, d); chk(d == 32'h5A, "R4 after empty read", d, 32'h5A);
    void'(rxq.pop_front());

    // R7 TX flush
    for (int i = 0; i < 5; i++) tx_put(8'h30 + 8'(i), 0);
    wr(4'd0, 32'h80);
    rd(4'd0, d); chk(d[7] == 1, "R7 tx flush busy", d, 32'h80);
    tx_rdy = 1;
    #1 chk(tx_vld == 0, "R7 tx blocked in flush", {31'd0, tx_vld}, 0);
    tx_rdy = 0;
    repeat (FLC) @(negedge clk);
    rd(4'd0, d); chk(d[7] == 0, "R7 tx flush done", d, 0);
    rd(4'd4, d); chk(d[0] == 1, "R7 tx empty after flush", d, 1);

    // R7 RX flush
    for (int i = 0; i < 3; i++) rx_send(8'h60 + 8'(i));
    rxq.delete();
    wr(4'd0, 32'h100);
    rd(4'd0, d); chk(d[8] == 1, "R7 rx flush busy", d, 32'h100);
    #1 chk(rx_rdy == 0, "R7 rx blocked in flush", {31'd0, rx_rdy}, 0);
    repeat (FLC) @(negedge clk);
    rd(4'd0, d); chk(d[8] == 0, "R7 rx flush done", d, 0);
    rd(4'd8, d); chk(d == 0, "R7 rx empty after flush", d, 0);

    // R8 events, R10 mask and irq
    pulse(1);
    repeat (3) @(negedge clk);
    rd(4'd4, d); chk(d[24] == 1, "R8 arb lost sticky", d, 32'h0100_0000);
    chk(irq == 0, "R10 irq masked off", {31'd0, irq}, 0);
    wr(4'd3, 32'h0100_0000);
    rd(4'd5, d); chk(d == 32'h0100_0000, "R10 masked status", d, 32'h0100_0000);
    chk(irq == 1, "R10 irq high", {31'd0, irq}, 1);
    wr(4'd6, 32'h0);
    rd(4'd4, d); chk(d[24] == 1, "R9 zero write no effect", d, 32'h0100_0000);
    wr(4'd6, 32'h0100_0000);
    rd(4'd4, d); chk(d[24] == 0, "R9 clear arb", d, 0);
    chk(irq == 0, "R10 irq low after clear", {31'd0, irq}, 0);
    pulse(0); pulse(3);
    rd(4'd4, d); chk(d[19] == 1 && d[28] == 1, "R8 done bits", d, 32'h1008_0000);
    // set wins over clear in the same cycle
    reg_wr = 1; reg_addr = 4'd6; reg_wdata = 32'h0200_0000; ev_bus_err = 1;
    @(negedge clk);
    reg_wr = 0; ev_bus_err = 0;
    rd(4'd4, d); chk(d[25] == 1, "R8 set beats clear", d, 32'h0200_0000);
    wr(4'd6, 32'h0000_0001);
    rd(4'd4, d); chk(d[0] == 1, "R9 level bit not clearable", d, 1);
    wr(4'd3, 32'hFFFF_FFFF);
    rd(4'd3, d); chk(d == 32'h1FFF_FFFF, "R10 mask reserved bits", d, 32'h1FFF_FFFF);
    begin
      logic [31:0] r;
      rd(4'd4, r);
      rd(4'd5, d); chk(d == (r & 32'h1FFF_FFFF), "R10 masked equals raw and mask", d, r);
    end
    wr(4'd6, 32'hFFFF_FFFF);
    rd(4'd4, d); chk(d == 32'h13, "R9 clear all sticky", d, 32'h13);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule